// File: doc/BRIEF.md
# Dual-Mode EEPROM Word-Address Pointer

This block holds the word address for a serial EEPROM and presents it to the memory array. A bus front end loads a full address when a transaction supplies one. After each byte it pulses an increment strobe that is tagged as a write step or a read step. A write step advances only the in-page offset, so a long write burst circles inside one 128-byte page and overwrites the earliest bytes in order. A read step advances the whole address, carrying across page boundaries, and wraps from the top of the array to zero.

Between transactions the pointer keeps its value. A later current-address read therefore starts one past the last byte touched. The pointer is a register, and every change appears on the clock edge after the strobe that asked for it.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: While `rstN` is low, `addrOut` is 0x0000, and it stays 0x0000 after release until a strobe arrives.
- R2: With `loadEn` high, `addrOut` equals `loadAddr` after the next rising clock edge.
- R3: When `loadEn` and `incEn` are both high in the same cycle, the load wins and the increment is dropped.
- R4: A write step (`incEn`=1, `incIsRead`=0) adds one to bits [6:0] and leaves bits [15:7] unchanged.
- R5: A write step at offset 0x7F within a page returns the pointer to offset 0x00 of the same page. For example, 0x217F becomes 0x2100 and 0xFFFF becomes 0xFF80.
- R6: A read step (`incEn`=1, `incIsRead`=1) adds one to the full 16-bit address and carries into the page bits. For example, 0x217F becomes 0x2180.
- R7: A read step at 0xFFFF gives 0x0000.
- R8: With neither `loadEn` nor `incEn` high, `addrOut` holds its value.
- R9: 128 write steps starting at a page's first byte visit each offset once, in ascending order, and return to that first byte.
- R10: `addrOut` is registered. It does not change between a strobe being raised and the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low; clears the pointer |
| loadEn | input | 1 | Replace the pointer with `loadAddr` |
| loadAddr | input | 16 | Address to load |
| incEn | input | 1 | Advance the pointer by one step |
| incIsRead | input | 1 | Step kind: 1 = read (whole-array wrap), 0 = write (in-page wrap) |
| addrOut | output | 16 | Current word address |

## Verification
A load and an increment can arrive in the same cycle. This happens when a front end starts a new transaction on the cycle that closes the previous byte. The bench raises both strobes together, once with a read step and once with a write step. It expects the loaded address and no trace of the step. It also raises both strobes with a load address that sits at a page edge, where a wrong priority would show up as a wrapped value.

// File: rtl/eeprom_addr_ptr_pkg.sv
package eeprom_addr_ptr_pkg;

  // Strobes passed from the control decode to the pointer datapath.
  // At most one field is high in any cycle.
  typedef struct packed {
    logic load;      // take the external address
    logic stepPage;  // advance the in-page offset only
    logic stepFull;  // advance the full address
  } ptrCtl_t;

endpackage

// File: rtl/eeprom_addr_ptr_ctl.sv
module eeprom_addr_ptr_ctl
  import eeprom_addr_ptr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadEn,
  input  logic    incEn,
  input  logic    incIsRead,
  output ptrCtl_t ctl
);

  // A load suppresses any step requested in the same cycle.
  always_comb begin
    ctl          = '0;
    ctl.load     = loadEn;
    ctl.stepPage = incEn && !incIsRead && !loadEn;
    ctl.stepFull = incEn &&  incIsRead && !loadEn;
  end

  // R3: the datapath never sees two competing strobes.
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.stepPage, ctl.stepFull}));

  // R3: a load request always reaches the datapath as a load.
  assert_load_passes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && incEn) |-> (ctl.load && !ctl.stepPage && !ctl.stepFull));

endmodule

// File: rtl/eeprom_addr_ptr_dp.sv
module eeprom_addr_ptr_dp
  import eeprom_addr_ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrCtl_t           ctl,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] ptrQ
);

  localparam int HIGH_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] ptrNext;
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] fullNext;
  logic [PAGE_W-1:0] lowStep;

  assign lowStep  = ptrQ[PAGE_W-1:0] + PAGE_W'(1);
  assign fullNext = ptrQ + ADDR_W'(1);

  generate
    if (HIGH_W > 0) begin : g_paged
      // Page bits are held, so the offset wraps inside the page.
      assign pageNext = {ptrQ[ADDR_W-1:PAGE_W], lowStep};

      // R4: a write step never moves the pointer to another page.
      assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
        ctl.stepPage |=> (ptrQ[ADDR_W-1:PAGE_W] == $past(ptrQ[ADDR_W-1:PAGE_W])));
    end else begin : g_flat
      // The page spans the whole array, so both steps behave alike.
      assign pageNext = lowStep;
    end
  endgenerate

  always_comb begin
    ptrNext = ptrQ;
    if (ctl.load)
      ptrNext = loadAddr;
    else if (ctl.stepFull)
      ptrNext = fullNext;
    else if (ctl.stepPage)
      ptrNext = pageNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ptrQ <= '0;
    else
      ptrQ <= ptrNext;
  end

  // R2: a loaded address appears one edge later.
  assert_load_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (ptrQ == $past(loadAddr)));

  // R5: a write step at the last offset returns to offset zero.
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepPage && (&ptrQ[PAGE_W-1:0])) |=> (ptrQ[PAGE_W-1:0] == '0));

  // R6: a read step moves the pointer up by exactly one.
  assert_read_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepFull && !(&ptrQ)) |=> (ptrQ == $past(ptrQ) + ADDR_W'(1)));

  // R7: a read step at the top of the array wraps to zero.
  assert_array_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepFull && (&ptrQ)) |=> (ptrQ == '0));

  // R8: without a strobe the pointer keeps its value.
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.stepPage && !ctl.stepFull) |=> $stable(ptrQ));

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr
  import eeprom_addr_ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              incEn,
  input  logic              incIsRead,
  output logic [ADDR_W-1:0] addrOut
);

  ptrCtl_t ctl;

  eeprom_addr_ptr_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .incEn     (incEn),
    .incIsRead (incIsRead),
    .ctl       (ctl)
  );

  eeprom_addr_ptr_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadAddr (loadAddr),
    .ptrQ     (addrOut)
  );

endmodule

// File: tb/eeprom_addr_ptr_tb.sv
module eeprom_addr_ptr_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] loadAddr = '0;
  logic        incEn = 1'b0;
  logic        incIsRead = 1'b0;
  logic [15:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eeprom_addr_ptr u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .loadAddr  (loadAddr),
    .incEn     (incEn),
    .incIsRead (incIsRead),
    .addrOut   (addrOut)
  );

  // Row layout: {reqNum[3:0], loadEn, loadAddr[15:0], incEn, incIsRead, expect[15:0]}
  localparam int NVEC = 14;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd2,  1'b1, 16'h1234, 1'b0, 1'b0, 16'h1234},  // R2 load
    {4'd4,  1'b0, 16'h0000, 1'b1, 1'b0, 16'h1235},  // R4 write step in page
    {4'd2,  1'b1, 16'h217F, 1'b0, 1'b0, 16'h217F},  // R2 load page edge
    {4'd5,  1'b0, 16'h0000, 1'b1, 1'b0, 16'h2100},  // R5 write wrap in page
    {4'd2,  1'b1, 16'h217F, 1'b0, 1'b0, 16'h217F},  // R2 reload
    {4'd6,  1'b0, 16'h0000, 1'b1, 1'b1, 16'h2180},  // R6 read carries into page bits
    {4'd8,  1'b0, 16'h0000, 1'b0, 1'b1, 16'h2180},  // R8 idle hold, step kind toggled
    {4'd2,  1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF},  // R2 load top
    {4'd7,  1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000},  // R7 read wraps array
    {4'd2,  1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF},  // R2 load top
    {4'd5,  1'b0, 16'h0000, 1'b1, 1'b0, 16'hFF80},  // R5 write wrap in last page
    {4'd3,  1'b1, 16'h4000, 1'b1, 1'b1, 16'h4000},  // R3 load beats read step
    {4'd3,  1'b1, 16'h007F, 1'b1, 1'b0, 16'h007F},  // R3 load beats write step at edge
    {4'd8,  1'b0, 16'hABCD, 1'b0, 1'b0, 16'h007F}   // R8 idle ignores loadAddr
  };

  task automatic check(input int req, input logic [15:0] exp);
    checks++;
    if (addrOut !== exp) begin
      errors++;
      $display("FAIL R%0d: addrOut=%h expected=%h", req, addrOut, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check.
  task automatic step(input logic ld, input logic [15:0] a, input logic inc,
                      input logic rd, input int req, input logic [15:0] exp);
    loadEn = ld; loadAddr = a; incEn = inc; incIsRead = rd;
    @(negedge clk);
    loadEn = 1'b0; incEn = 1'b0; incIsRead = 1'b0;
    check(req, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(1, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][34], VEC[i][33:18], VEC[i][17], VEC[i][16],
           int'(VEC[i][38:35]), VEC[i][15:0]);
    end

    // R9: full lap of write steps around page 0x74
    step(1'b1, 16'h3A00, 1'b0, 1'b0, 2, 16'h3A00);
    model = 16'h3A00;
    for (int i = 0; i < 128; i++) begin
      model = {model[15:7], model[6:0] + 7'd1};
      step(1'b0, 16'h0000, 1'b1, 1'b0, 9, model);
    end
    check(9, 16'h3A00);

    // R10: output unchanged before the edge, updated after it
    loadEn = 1'b1; loadAddr = 16'h0F0F;
    #1;
    check(10, 16'h3A00);
    @(negedge clk);
    loadEn = 1'b0;
    check(10, 16'h0F0F);
    incEn = 1'b1; incIsRead = 1'b1;
    #2;
    check(10, 16'h0F0F);
    @(negedge clk);
    incEn = 1'b0; incIsRead = 1'b0;
    check(10, 16'h0F10);

    // R1: mid-run reset clears, value stays zero after release
    rstN = 1'b0;
    #1;
    check(1, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 16'h0000);

    // R7 then R6: read across array top continues upward
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, 2, 16'hFFFF);
    step(1'b0, 16'h0000, 1'b1, 1'b1, 7, 16'h0000);
    step(1'b0, 16'h0000, 1'b1, 1'b1, 6, 16'h0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule